// File: doc/BRIEF.md
# Byte-Lane Timing Window Centering Engine

This block finds the centre of the passing delay window for a set of byte lanes during memory interface timing training. A pattern sweep feeds it, one pattern at a time, the first passing tap and the last passing tap of every data bit in every lane. It also feeds a lock flag from each of the two search directions. Each lane keeps a running worst-case window: the latest start seen and the earliest end seen. It checks that window after every pattern and marks the lane failed when the window is unusable or when a search did not lock and the fault cannot be repaired.

A run begins with a start pulse. The pulse captures the direction (write or read), a debug flag and a lane-enable mask. The run ends after a fixed number of patterns, or sooner when a lane's window turns invalid and debug is clear. At the end the block gives, for every lane, a centred tap, a window length, a state code and a pass flag. It also gives a copy of a caller-supplied word with the window length inserted into a 5-bit field, plus an overall fail flag and an abort flag. All results appear together with a one-cycle done strobe.

Top module: `lane_center_engine`

## Requirements
- R1: After reset, done_o, abort_o and if_fail_o are 0 and every result output (centre, length, state, pass, length word) is 0.
- R2: start_i captures mode_tx_i, debug_i and lane_act_i and sets every lane window to start 0 and end (max_win-1)+offset. The offset is TX_OFF (64) in write mode and 0 in read mode. max_win is MAXW_TX (64) in write mode and MAXW_RX (32) in read mode. For each accepted pattern, the lane start becomes the larger of itself and the largest bit start, and the lane end becomes the smaller of itself and the smallest bit end.
- R3: When lock_up_i and lock_dn_i of a lane are not both 1, every bit with start>0 and end==0 has its end replaced by max_win-1 before the update. If any bit does not match that case, the lane enters state 1 and its window is left unchanged. This does not end the run.
- R4: A lane in state 1 ignores all later patterns of the run, and its window stays frozen.
- R5: After each update the window is valid if any of these holds: end+1 > start+MIN_WIN (10) and end+1 < start+max_win; start==0 and end!=0; start!=max_win-1 and end==max_win-1. An invalid window puts the lane in state 1 but keeps the updated window. When debug is clear, the run also stops and reports abort_o=1.
- R6: pat_valid_i is only accepted while a run is active. A run without an abort accepts exactly NUM_PAT (8) patterns. Let the pattern that ends the run be sampled at clock edge k. Then done_o is 1 for exactly one cycle, from edge k+1 to edge k+2, and all results change at edge k+1.
- R7: At the end of a run, a lane not in state 1 whose span end-start (8-bit) lies strictly between 2 and MIN_WIN reports state 2 if end==max_win-1, or state 3 if end==0. Otherwise it reports state 0.
- R8: The centre is ((end+start)>>1) minus the result offset, taken modulo 256. The result offset is TX_OFF when in write mode with end > max_win-1, and 0 otherwise. The length is end-start+1, taken modulo 256. Both are reported for active lanes whatever their state.
- R9: For a passing lane, len_word_o equals len_word_i with bits [TX_LSB+4:TX_LSB] (bit 0 in write mode) or [RX_LSB+4:RX_LSB] (bit 8 in read mode) replaced by the low 5 bits of the length. For failed and inactive lanes, len_word_o equals len_word_i.
- R10: A lane whose bit in lane_act_i is 0 reports state 0, pass 0, centre 0 and length 0, and can never cause a fail or an abort.
- R11: lane_pass_o is 1 exactly for active lanes not in state 1. if_fail_o is 1 when the run aborted or any active lane ends in state 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run; captures mode, debug and lane mask |
| mode_tx_i | input | 1 | 1 = write centring, 0 = read centring |
| debug_i | input | 1 | 1 = keep running after an invalid window |
| lane_act_i | input | NUM_LANES | Lane enable mask |
| pat_valid_i | input | 1 | One pattern result present this cycle |
| start_taps_i | input | NUM_LANES*BITS*TAP_W | Per-bit first passing tap, lane-major then bit |
| end_taps_i | input | NUM_LANES*BITS*TAP_W | Per-bit last passing tap, same packing |
| lock_up_i | input | NUM_LANES | Low-to-high search locked, per lane |
| lock_dn_i | input | NUM_LANES | High-to-low search locked, per lane |
| len_word_i | input | NUM_LANES*WORD_W | Word that receives the length field, per lane |
| done_o | output | 1 | One-cycle result strobe |
| abort_o | output | 1 | Run stopped early on an invalid window |
| if_fail_o | output | 1 | Abort, or some active lane failed |
| center_o | output | NUM_LANES*TAP_W | Centred tap per lane |
| win_len_o | output | NUM_LANES*TAP_W | Window length per lane |
| lane_state_o | output | NUM_LANES*2 | State code per lane (0 ok, 1 fail, 2/3 false lock) |
| lane_pass_o | output | NUM_LANES | Lane succeeded |
| len_word_o | output | NUM_LANES*WORD_W | Length word with the field inserted |

## Verification
A lane window register that drifts the wrong way surfaces only at the done strobe, as a wrong centre or length. The bench therefore derives each lane's expected centre and length from its own sweep and compares them on every run. A fail flag that sets or clears wrongly shows up as a wrong state code and pass flag, and, in a lane that should be frozen, as a length that still follows the later, narrower patterns. A pattern counter or phase error moves the done strobe by one or more cycles, so the strobe position is sampled cycle by cycle around the last accepted pattern.

// File: rtl/lcw_pkg.sv
package lcw_pkg;
  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_FAIL    = 2'd1,
    ST_EDGE_HI = 2'd2,
    ST_EDGE_LO = 2'd3
  } lane_st_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_RUN,
    PH_FIN
  } phase_e;

  localparam int LEN_FW = 5;
endpackage

// File: rtl/lcw_lane_track.sv
module lcw_lane_track #(
  parameter int TAP_W   = 8,
  parameter int BITS    = 8,
  parameter int MIN_WIN = 10,
  parameter int MAXW_TX = 64,
  parameter int MAXW_RX = 32,
  parameter int TX_OFF  = 64
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  init_i,
  input  logic                  upd_i,
  input  logic                  mode_tx_i,
  input  logic                  lock_ok_i,
  input  logic [BITS*TAP_W-1:0] start_taps_i,
  input  logic [BITS*TAP_W-1:0] end_taps_i,
  output logic [TAP_W-1:0]      win_s_o,
  output logic [TAP_W-1:0]      win_e_o,
  output logic                  fail_o,
  output logic                  bad_win_o
);
  localparam logic [TAP_W:0] MW_TX = (TAP_W+1)'(MAXW_TX);
  localparam logic [TAP_W:0] MW_RX = (TAP_W+1)'(MAXW_RX);
  localparam logic [TAP_W:0] MINW  = (TAP_W+1)'(MIN_WIN);

  logic [TAP_W-1:0] s_q, e_q, mw_m1, smax, emin, sb, eb, nstart, nend;
  logic [TAP_W:0]   mw, e1;
  logic             fail_q, patch_bad, win_ok;

  assign mw    = mode_tx_i ? MW_TX : MW_RX;
  assign mw_m1 = mw[TAP_W-1:0] - 1'b1;

  // worst bit across the byte, with one-sided lock repair
  always_comb begin
    smax = '0;
    emin = '1;
    patch_bad = 1'b0;
    sb = '0;
    eb = '0;
    for (int b = 0; b < BITS; b++) begin
      sb = start_taps_i[b*TAP_W +: TAP_W];
      eb = end_taps_i[b*TAP_W +: TAP_W];
      if (!lock_ok_i) begin
        if (sb != '0 && eb == '0) eb = mw_m1;
        else patch_bad = 1'b1;
      end
      if (sb > smax) smax = sb;
      if (eb < emin) emin = eb;
    end
  end

  assign nstart = (smax > s_q) ? smax : s_q;
  assign nend   = (emin < e_q) ? emin : e_q;
  assign e1     = {1'b0, nend} + 1'b1;

  assign win_ok = ((e1 > {1'b0, nstart} + MINW) && (e1 < {1'b0, nstart} + mw))
               || (nstart == '0 && nend != '0)
               || (nstart != mw_m1 && nend == mw_m1);

  assign bad_win_o = upd_i && !fail_q && !patch_bad && !win_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_q    <= '0;
      e_q    <= '0;
      fail_q <= 1'b0;
    end else if (init_i) begin
      s_q    <= '0;
      e_q    <= mw_m1 + (mode_tx_i ? TAP_W'(TX_OFF) : '0);
      fail_q <= 1'b0;
    end else if (upd_i && !fail_q) begin
      if (patch_bad) begin
        fail_q <= 1'b1;
      end else begin
        s_q <= nstart;
        e_q <= nend;
        if (!win_ok) fail_q <= 1'b1;
      end
    end
  end

  assign win_s_o = s_q;
  assign win_e_o = e_q;
  assign fail_o  = fail_q;
endmodule

// File: rtl/lcw_lane_result.sv
module lcw_lane_result
  import lcw_pkg::*;
#(
  parameter int TAP_W   = 8,
  parameter int MIN_WIN = 10,
  parameter int MAXW_TX = 64,
  parameter int MAXW_RX = 32,
  parameter int TX_OFF  = 64,
  parameter int WORD_W  = 16,
  parameter int TX_LSB  = 0,
  parameter int RX_LSB  = 8
) (
  input  logic              act_i,
  input  logic              mode_tx_i,
  input  logic              fail_i,
  input  logic [TAP_W-1:0]  win_s_i,
  input  logic [TAP_W-1:0]  win_e_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [TAP_W-1:0]  center_o,
  output logic [TAP_W-1:0]  len_o,
  output lane_st_e          state_o,
  output logic              pass_o,
  output logic [WORD_W-1:0] word_o
);
  localparam logic [WORD_W-1:0] FMASK = WORD_W'((1 << LEN_FW) - 1);

  logic [TAP_W-1:0] mw_m1, span, off, len;
  logic [TAP_W:0]   sum;
  logic             narrow;
  int               pos;

  assign mw_m1  = mode_tx_i ? TAP_W'(MAXW_TX - 1) : TAP_W'(MAXW_RX - 1);
  assign span   = win_e_i - win_s_i;
  assign narrow = (span < TAP_W'(MIN_WIN)) && (span > TAP_W'(2));
  assign off    = (mode_tx_i && win_e_i > mw_m1) ? TAP_W'(TX_OFF) : '0;
  assign sum    = {1'b0, win_e_i} + {1'b0, win_s_i};
  assign len    = span + 1'b1;
  assign pos    = mode_tx_i ? TX_LSB : RX_LSB;

  always_comb begin
    center_o = '0;
    len_o    = '0;
    state_o  = ST_OK;
    pass_o   = 1'b0;
    word_o   = word_i;
    if (act_i) begin
      center_o = sum[TAP_W:1] - off;
      len_o    = len;
      if (fail_i)                        state_o = ST_FAIL;
      else if (narrow && win_e_i == mw_m1) state_o = ST_EDGE_HI;
      else if (narrow && win_e_i == '0)    state_o = ST_EDGE_LO;
      pass_o = !fail_i;
      if (!fail_i)
        word_o = (word_i & ~(FMASK << pos)) | ((WORD_W'(len[LEN_FW-1:0])) << pos);
    end
  end
endmodule

// File: rtl/lane_center_engine.sv
module lane_center_engine
  import lcw_pkg::*;
#(
  parameter int NUM_LANES = 2,
  parameter int BITS      = 8,
  parameter int TAP_W     = 8,
  parameter int NUM_PAT   = 8,
  parameter int MIN_WIN   = 10,
  parameter int MAXW_TX   = 64,
  parameter int MAXW_RX   = 32,
  parameter int TX_OFF    = 64,
  parameter int WORD_W    = 16,
  parameter int TX_LSB    = 0,
  parameter int RX_LSB    = 8
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            start_i,
  input  logic                            mode_tx_i,
  input  logic                            debug_i,
  input  logic [NUM_LANES-1:0]            lane_act_i,
  input  logic                            pat_valid_i,
  input  logic [NUM_LANES*BITS*TAP_W-1:0] start_taps_i,
  input  logic [NUM_LANES*BITS*TAP_W-1:0] end_taps_i,
  input  logic [NUM_LANES-1:0]            lock_up_i,
  input  logic [NUM_LANES-1:0]            lock_dn_i,
  input  logic [NUM_LANES*WORD_W-1:0]     len_word_i,
  output logic                            done_o,
  output logic                            abort_o,
  output logic                            if_fail_o,
  output logic [NUM_LANES*TAP_W-1:0]      center_o,
  output logic [NUM_LANES*TAP_W-1:0]      win_len_o,
  output logic [NUM_LANES*2-1:0]          lane_state_o,
  output logic [NUM_LANES-1:0]            lane_pass_o,
  output logic [NUM_LANES*WORD_W-1:0]     len_word_o
);
  localparam int CNT_W = (NUM_PAT > 1) ? $clog2(NUM_PAT) : 1;
  localparam int LBITS = BITS * TAP_W;

  phase_e               ph_q;
  logic [CNT_W-1:0]     cnt_q;
  logic                 mode_q, dbg_q, abort_q, mode_sel, run, abort_now;
  logic [NUM_LANES-1:0] act_q, bad_w, fail_w, pass_w, st_fail_w;

  logic [NUM_LANES*TAP_W-1:0]  win_s_w, win_e_w, cen_w, len_w;
  logic [NUM_LANES*2-1:0]      st_w;
  logic [NUM_LANES*WORD_W-1:0] word_w;

  assign mode_sel  = start_i ? mode_tx_i : mode_q;
  assign run       = (ph_q == PH_RUN) && !start_i;
  assign abort_now = !dbg_q && (|bad_w);

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    lane_st_e st;

    lcw_lane_track #(
      .TAP_W(TAP_W), .BITS(BITS), .MIN_WIN(MIN_WIN),
      .MAXW_TX(MAXW_TX), .MAXW_RX(MAXW_RX), .TX_OFF(TX_OFF)
    ) u_track (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .init_i      (start_i),
      .upd_i       (run && pat_valid_i && act_q[i]),
      .mode_tx_i   (mode_sel),
      .lock_ok_i   (lock_up_i[i] && lock_dn_i[i]),
      .start_taps_i(start_taps_i[i*LBITS +: LBITS]),
      .end_taps_i  (end_taps_i[i*LBITS +: LBITS]),
      .win_s_o     (win_s_w[i*TAP_W +: TAP_W]),
      .win_e_o     (win_e_w[i*TAP_W +: TAP_W]),
      .fail_o      (fail_w[i]),
      .bad_win_o   (bad_w[i])
    );

    lcw_lane_result #(
      .TAP_W(TAP_W), .MIN_WIN(MIN_WIN), .MAXW_TX(MAXW_TX), .MAXW_RX(MAXW_RX),
      .TX_OFF(TX_OFF), .WORD_W(WORD_W), .TX_LSB(TX_LSB), .RX_LSB(RX_LSB)
    ) u_res (
      .act_i    (act_q[i]),
      .mode_tx_i(mode_q),
      .fail_i   (fail_w[i]),
      .win_s_i  (win_s_w[i*TAP_W +: TAP_W]),
      .win_e_i  (win_e_w[i*TAP_W +: TAP_W]),
      .word_i   (len_word_i[i*WORD_W +: WORD_W]),
      .center_o (cen_w[i*TAP_W +: TAP_W]),
      .len_o    (len_w[i*TAP_W +: TAP_W]),
      .state_o  (st),
      .pass_o   (pass_w[i]),
      .word_o   (word_w[i*WORD_W +: WORD_W])
    );

    assign st_w[i*2 +: 2] = st;
    assign st_fail_w[i]   = (st == ST_FAIL);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q         <= PH_IDLE;
      cnt_q        <= '0;
      mode_q       <= 1'b0;
      dbg_q        <= 1'b0;
      act_q        <= '0;
      abort_q      <= 1'b0;
      done_o       <= 1'b0;
      abort_o      <= 1'b0;
      if_fail_o    <= 1'b0;
      center_o     <= '0;
      win_len_o    <= '0;
      lane_state_o <= '0;
      lane_pass_o  <= '0;
      len_word_o   <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        ph_q    <= PH_RUN;
        cnt_q   <= '0;
        mode_q  <= mode_tx_i;
        dbg_q   <= debug_i;
        act_q   <= lane_act_i;
        abort_q <= 1'b0;
      end else begin
        unique case (ph_q)
          PH_RUN: if (pat_valid_i) begin
            cnt_q   <= cnt_q + 1'b1;
            abort_q <= abort_now;
            if (abort_now || cnt_q == CNT_W'(NUM_PAT - 1)) ph_q <= PH_FIN;
          end
          PH_FIN: begin
            ph_q         <= PH_IDLE;
            done_o       <= 1'b1;
            abort_o      <= abort_q;
            if_fail_o    <= abort_q || (|st_fail_w);
            center_o     <= cen_w;
            win_len_o    <= len_w;
            lane_state_o <= st_w;
            lane_pass_o  <= pass_w;
            len_word_o   <= word_w;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/lane_center_engine_chk.sv
module lane_center_engine_chk #(
  parameter int NUM_LANES = 2,
  parameter int TAP_W     = 8
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       start_i,
  input logic                       done_o,
  input logic                       abort_o,
  input logic                       if_fail_o,
  input logic [NUM_LANES*TAP_W-1:0] win_s_w,
  input logic [NUM_LANES*TAP_W-1:0] win_e_w,
  input logic [NUM_LANES-1:0]       fail_w
);
  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r11_abort_is_fail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> if_fail_o);

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_l
    a_r2_start_nondec: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !start_i |=> win_s_w[i*TAP_W +: TAP_W] >= $past(win_s_w[i*TAP_W +: TAP_W]));

    a_r2_end_noninc: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !start_i |=> win_e_w[i*TAP_W +: TAP_W] <= $past(win_e_w[i*TAP_W +: TAP_W]));

    a_r4_fail_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fail_w[i] && !start_i) |=> (fail_w[i]
        && $stable(win_s_w[i*TAP_W +: TAP_W]) && $stable(win_e_w[i*TAP_W +: TAP_W])));
  end
endmodule

bind lane_center_engine lane_center_engine_chk #(
  .NUM_LANES(NUM_LANES), .TAP_W(TAP_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .done_o   (done_o),
  .abort_o  (abort_o),
  .if_fail_o(if_fail_o),
  .win_s_w  (win_s_w),
  .win_e_w  (win_e_w),
  .fail_w   (fail_w)
);

// File: tb/lane_center_engine_tb.sv
module lane_center_engine_tb;
  localparam int NL = 2;
  localparam int NB = 8;
  localparam int TW = 8;
  localparam int WW = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, mode_tx_i = 1'b0, debug_i = 1'b0, pat_valid_i = 1'b0;
  logic [NL-1:0] lane_act_i = '1, lock_up_i = '1, lock_dn_i = '1;
  logic [NL*NB*TW-1:0] start_taps_i, end_taps_i;
  logic [NL*WW-1:0] len_word_i;
  logic done_o, abort_o, if_fail_o;
  logic [NL*TW-1:0] center_o, win_len_o;
  logic [NL*2-1:0] lane_state_o;
  logic [NL-1:0] lane_pass_o;
  logic [NL*WW-1:0] len_word_o;

  logic [TW-1:0] st_t [NL][NB];
  logic [TW-1:0] en_t [NL][NB];
  logic [WW-1:0] wi [NL];
  int vectors = 0, errors = 0;

  always #5 clk = ~clk;

  always_comb begin
    for (int l = 0; l < NL; l++) begin
      len_word_i[l*WW +: WW] = wi[l];
      for (int b = 0; b < NB; b++) begin
        start_taps_i[(l*NB+b)*TW +: TW] = st_t[l][b];
        end_taps_i[(l*NB+b)*TW +: TW]   = en_t[l][b];
      end
    end
  end

  lane_center_engine u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .mode_tx_i(mode_tx_i),
    .debug_i(debug_i), .lane_act_i(lane_act_i), .pat_valid_i(pat_valid_i),
    .start_taps_i(start_taps_i), .end_taps_i(end_taps_i),
    .lock_up_i(lock_up_i), .lock_dn_i(lock_dn_i), .len_word_i(len_word_i),
    .done_o(done_o), .abort_o(abort_o), .if_fail_o(if_fail_o),
    .center_o(center_o), .win_len_o(win_len_o), .lane_state_o(lane_state_o),
    .lane_pass_o(lane_pass_o), .len_word_o(len_word_o)
  );

  task automatic chk(string tag, int got, int exp);
    vectors++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d (0x%0h) exp %0d (0x%0h)", tag, got, got, exp, exp);
    end
  endtask

  task automatic set_lane(int l, int s_lo, int s_hi, int e_lo, int e_hi);
    for (int b = 0; b < NB; b++) begin
      st_t[l][b] = TW'(s_lo);
      en_t[l][b] = TW'(e_hi);
    end
    st_t[l][1] = TW'(s_hi);
    en_t[l][5] = TW'(e_lo);
  endtask

  task automatic begin_run(bit tx, bit dbg, logic [NL-1:0] act);
    @(negedge clk);
    start_i = 1'b1; mode_tx_i = tx; debug_i = dbg; lane_act_i = act;
    lock_up_i = '1; lock_dn_i = '1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic push_pat();
    pat_valid_i = 1'b1;
    @(negedge clk);
    pat_valid_i = 1'b0;
  endtask

  // after the final pattern: strobe is low now, high next cycle, low after
  task automatic chk_done_timing(string tag);
    chk({tag, " done low at k"}, int'(done_o), 0);
    @(negedge clk);
    chk({tag, " done high at k+1"}, int'(done_o), 1);
    @(negedge clk);
    chk({tag, " done low at k+2"}, int'(done_o), 0);
  endtask

  task automatic chk_lane(string tag, int l, int st, int ps, int cen, int len, int word);
    chk({tag, " state"},  int'(lane_state_o[l*2 +: 2]), st);
    chk({tag, " pass"},   int'(lane_pass_o[l]), ps);
    chk({tag, " center"}, int'(center_o[l*TW +: TW]), cen);
    chk({tag, " len"},    int'(win_len_o[l*TW +: TW]), len);
    chk({tag, " word"},   int'(len_word_o[l*WW +: WW]), word);
  endtask

  task automatic t_reset();
    chk("R1 done", int'(done_o), 0);
    chk("R1 abort", int'(abort_o), 0);
    chk("R1 if_fail", int'(if_fail_o), 0);
    chk("R1 center", int'(center_o), 0);
    chk("R1 len", int'(win_len_o), 0);
    chk("R1 state", int'(lane_state_o), 0);
    chk("R1 pass", int'(lane_pass_o), 0);
    chk("R1 word", int'(len_word_o), 0);
  endtask

  task automatic t_rx_sweep();
    wi[0] = 16'hFFFF; wi[1] = 16'h0000;
    begin_run(1'b0, 1'b0, 2'b11);
    for (int p = 0; p < 8; p++) begin
      set_lane(0, 1, 2 + p, 28 - p, 30);
      set_lane(1, 4, 4, 25, 25);
      push_pat();
      if (p == 6) chk("R6 no done after 7 patterns", int'(done_o), 0);
    end
    chk_done_timing("R6 rx");
    chk_lane("R2 R8 R9 rx lane0", 0, 0, 1, 15, 13, 16'hEDFF);
    chk_lane("R2 R8 R9 rx lane1", 1, 0, 1, 14, 22, 16'h1600);
    chk("R11 rx if_fail", int'(if_fail_o), 0);
    chk("R11 rx abort", int'(abort_o), 0);
  endtask

  task automatic t_tx_offset();
    wi[0] = 16'hFFFF; wi[1] = 16'h0000;
    begin_run(1'b1, 1'b0, 2'b11);
    for (int p = 0; p < 8; p++) begin
      set_lane(0, 50, 50, 100, 100);
      set_lane(1, 5, 5, 40, 40);
      push_pat();
    end
    chk_done_timing("R6 tx");
    chk_lane("R8 R9 tx wide lane0", 0, 0, 1, 11, 51, 16'hFFF3);
    chk_lane("R8 R9 tx lane1", 1, 0, 1, 22, 36, 16'h0004);
  endtask

  task automatic t_false_lock();
    wi[0] = 16'hFFFF; wi[1] = 16'h0000;
    begin_run(1'b0, 1'b0, 2'b11);
    for (int p = 0; p < 8; p++) begin
      set_lane(0, 20, 25, 31, 31);
      set_lane(1, 29, 29, 31, 31);
      push_pat();
    end
    chk_done_timing("R6 fl");
    chk_lane("R7 span 6 at top edge", 0, 2, 1, 28, 7, 16'hE7FF);
    chk_lane("R7 span 2 stays ok", 1, 0, 1, 30, 3, 16'h0300);
    chk("R11 fl if_fail", int'(if_fail_o), 0);
  endtask

  task automatic t_lock_patch();
    wi[0] = 16'hFFFF; wi[1] = 16'h1234;
    begin_run(1'b0, 1'b0, 2'b11);
    set_lane(0, 3, 3, 0, 0);
    set_lane(1, 3, 3, 0, 0);
    st_t[1][2] = 8'd0;
    lock_up_i = 2'b01; lock_dn_i = 2'b10;
    push_pat();
    lock_up_i = '1; lock_dn_i = '1;
    for (int p = 1; p < 8; p++) begin
      set_lane(0, 3, 3, 25, 25);
      set_lane(1, 10, 10, 15, 15);
      push_pat();
    end
    chk_done_timing("R6 lk");
    chk_lane("R3 patched lane0", 0, 0, 1, 14, 23, 16'hF7FF);
    chk_lane("R3 R4 frozen lane1", 1, 1, 0, 15, 32, 16'h1234);
    chk("R3 R11 lk if_fail", int'(if_fail_o), 1);
    chk("R3 lk no abort", int'(abort_o), 0);
  endtask

  task automatic t_abort(bit dbg);
    wi[0] = 16'h0000; wi[1] = 16'hABCD;
    begin_run(1'b0, dbg, 2'b11);
    for (int p = 0; p < 8; p++) begin
      set_lane(0, 4, 4, 25, 25);
      if (p < 3) set_lane(1, 4, 4, 25, 25);
      else if (p == 3) set_lane(1, 10, 10, 12, 12);
      else set_lane(1, 11, 11, 11, 11);
      push_pat();
      if (!dbg && p == 3) break;
      if (dbg && p == 3) chk("R5 debug run continues", int'(done_o), 0);
    end
    chk_done_timing(dbg ? "R5 dbg" : "R5 abort");
    chk("R5 abort flag", int'(abort_o), dbg ? 0 : 1);
    chk("R5 R11 if_fail", int'(if_fail_o), 1);
    chk_lane("R5 good lane0", 0, 0, 1, 14, 22, 16'h1600);
    chk_lane("R5 R4 bad lane1", 1, 1, 0, 11, 3, 16'hABCD);
  endtask

  task automatic t_inactive();
    wi[0] = 16'h0000; wi[1] = 16'h5A5A;
    begin_run(1'b0, 1'b0, 2'b01);
    for (int p = 0; p < 8; p++) begin
      set_lane(0, 4, 4, 25, 25);
      set_lane(1, 10, 10, 12, 12);
      lock_up_i[1] = (p != 0);
      push_pat();
    end
    lock_up_i = '1;
    chk_done_timing("R6 ina");
    chk_lane("R10 inactive lane1", 1, 0, 0, 0, 0, 16'h5A5A);
    chk_lane("R10 active lane0", 0, 0, 1, 14, 22, 16'h1600);
    chk("R10 no fail", int'(if_fail_o), 0);
    chk("R10 no abort", int'(abort_o), 0);
  endtask

  task automatic t_idle_ignore();
    set_lane(0, 10, 10, 12, 12);
    push_pat();
    push_pat();
    @(negedge clk);
    chk("R6 idle no done", int'(done_o), 0);
    chk("R6 idle center held", int'(center_o[0 +: TW]), 14);
    chk("R6 idle len held", int'(win_len_o[0 +: TW]), 22);
  endtask

  initial begin
    for (int l = 0; l < NL; l++) begin
      wi[l] = '0;
      set_lane(l, 0, 0, 0, 0);
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_rx_sweep();
    t_tx_offset();
    t_false_lock();
    t_lock_patch();
    t_abort(1'b0);
    t_abort(1'b1);
    t_inactive();
    t_idle_ignore();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule